// File: doc/BRIEF.md
# CCD Line Readout Timing Generator

This block produces every clock and marker that a frame-transfer CCD needs for one video line. It runs on a clock at six times the pixel rate. Each pixel period therefore splits into six sub-phases. From one counter pair (sub-phase, pixel) it decodes three outputs. The first is the three horizontal register phases with the reset-gate pulse. The second is the line markers: start-stop, composite blanking, black clamp, pixel-valid and line-start. The third is the vertical activity inside the line blanking gap: one full four-phase storage cycle that drops a line into the output register, an image-gate charge pump that walks the charge forward and back again, and an optional charge-reset pulse for electronic shuttering.

A frame-level sequencer gates the block through `run`. While `run` is high the block cycles line after line. When `run` falls the block returns to idle, and the next rising `run` starts a fresh line at pixel count 0. The mirror request reverses the register transfer direction. The mirror request and the shutter request are both taken only at the first sub-phase of a line, so each line is uniform.

All outputs are registered and reflect the current counter state. With the default parameters a line is 1152 pixel periods. The first 72 periods form the stopped-register window. The readout then shifts out 7 dummy, 20 black, 4 timing, 1024 active, 4 timing and 20 black cells; the line ends after one trailing dummy.

Top module: `ccd_line_timer`

## Requirements
- R1: During reset, and on every clock after `run` is seen low, all outputs are 0. The first clock with `run` high starts pixel count 0, sub-phase 0.
- R2: `lstart_o` is high for exactly the first sub-phase of pixel 0. While `run` stays high, line starts repeat every 1152 × 6 clocks.
- R3: Outside the stopped window, with normal direction, `hreg_o[0]` is high in sub-phases 0–2, `hreg_o[1]` in sub-phases 2–4, and `hreg_o[2]` in sub-phases 4, 5 and 0.
- R4: For pixel counts 0–71, `stop_o` is high and the register phases are frozen at `hreg_o` = 3'b001 (normal direction).
- R5: When the mirror request is latched, bits 0 and 1 of `hreg_o` are swapped, including the frozen level (3'b010). The request is latched only at line start, and changes during a line have no effect on that line.
- R6: `rg_o` is high only in sub-phase 0 of pixel counts 72–1151.
- R7: `pvalid_o` is high for pixel counts 103–1126 (the 1024 active cells) in all sub-phases.
- R8: `clamp_o` is high for pixel counts 79–98 and 1131–1150 (the two black-reference groups).
- R9: `blank_o` is high for pixel counts 1131–1151 and 0–99.
- R10: `stor_o` performs one storage cycle over pixel counts 19–66 in eight steps of six pixels. With bit k as phase k, step n (n = 1…7) takes the state t = n, and the rest state t = 0 is 4'b0110. State t drives phase k low when (t − 2k) mod 8 < 3.
- R11: `img_o` uses the same state encoding over pixel counts 19–66. Its step states run 1, 2, 3, 4, 3, 2, 1, 0, and the rest state outside the window is 4'b0110.
- R12: When the shutter request is latched at line start, `crst_o` is high for pixel counts 19–64 in that line. The request is ignored mid-line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sub-phase clock, six cycles per pixel |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Gate from the frame sequencer; low forces idle |
| mirror | input | 1 | Mirrored-readout request, taken at line start |
| shutter | input | 1 | Charge-reset request, taken at line start |
| hreg_o | output | 3 | Horizontal register phases, bit 0 = first phase |
| rg_o | output | 1 | Reset-gate pulse |
| stor_o | output | 4 | Storage-section phases |
| img_o | output | 4 | Image-section phases |
| crst_o | output | 1 | Charge-reset pulse |
| stop_o | output | 1 | Stopped-register window marker |
| blank_o | output | 1 | Composite blanking marker |
| clamp_o | output | 1 | Black-reference clamp strobe |
| pvalid_o | output | 1 | Active-pixel strobe |
| lstart_o | output | 1 | Line-start strobe |

## Verification
The assertions assume that `run` is the only thing that breaks line continuity. A line that `run` does not interrupt always runs to its full length. The mirror latch is therefore only required to hold between line starts while the block is active. The stimulus changes `mirror` and `shutter` at points in the middle of a line, drops `run` partway through a line and raises it again, and otherwise holds `run` high across several complete lines. Line boundaries, the stopped window and the register-phase rotation are covered in both directions.

// File: rtl/ccd_lt_pkg.sv
package ccd_lt_pkg;

  localparam int SUBS     = 6;
  localparam int VSTATES  = 8;
  localparam logic [3:0] VREST = 4'b0110;

  // Register phase k is high for three sub-phases starting at 2k.
  function automatic logic [2:0] hphase(input int s);
    logic [2:0] r;
    for (int k = 0; k < 3; k++) begin
      r[k] = (((s - 2 * k + SUBS) % SUBS) < 3);
    end
    return r;
  endfunction

  // Four-phase vertical state: phase k low when (t - 2k) mod 8 < 3.
  function automatic logic [3:0] four_phase(input int t);
    logic [3:0] r;
    for (int k = 0; k < 4; k++) begin
      r[k] = (((t - 2 * k + 2 * VSTATES) % VSTATES) >= 3);
    end
    return r;
  endfunction

  // Charge pump walks forward four states then back to rest.
  function automatic int pump_state(input int w);
    return (w < 4) ? (w + 1) : (7 - w);
  endfunction

  // Half-open span test on plain integers.
  function automatic logic in_span(input int p, input int lo, input int len);
    return (p >= lo) && (p < lo + len);
  endfunction

endpackage

// File: rtl/ccd_lt_seq.sv
module ccd_lt_seq #(
  parameter int LINE  = 1152,
  parameter int PIX_W = 11,
  parameter int SUB_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             mirror,
  input  logic             shutter,
  output logic [PIX_W-1:0] nxt_pix,
  output logic [SUB_W-1:0] nxt_sub,
  output logic             nxt_act,
  output logic             nxt_mir,
  output logic             nxt_cr,
  output logic [PIX_W-1:0] pix_q,
  output logic [SUB_W-1:0] sub_q,
  output logic             act_q,
  output logic             mir_q,
  output logic             cr_q
);
  import ccd_lt_pkg::*;

  localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(LINE - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUBS - 1);

  logic sub_wrap;
  logic at_start;

  assign sub_wrap = (sub_q == SUB_LAST);

  always_comb begin
    nxt_mir = mir_q;
    nxt_cr  = cr_q;
    if (!run) begin
      nxt_act = 1'b0;
      nxt_pix = PIX_LAST;
      nxt_sub = SUB_LAST;
    end else begin
      nxt_act = 1'b1;
      nxt_sub = sub_wrap ? '0 : sub_q + 1'b1;
      if (sub_wrap) begin
        nxt_pix = (pix_q == PIX_LAST) ? '0 : pix_q + 1'b1;
      end else begin
        nxt_pix = pix_q;
      end
    end
    at_start = run && (nxt_pix == '0) && (nxt_sub == '0);
    if (at_start) begin
      nxt_mir = mirror;
      nxt_cr  = shutter;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q <= PIX_LAST;
      sub_q <= SUB_LAST;
      act_q <= 1'b0;
      mir_q <= 1'b0;
      cr_q  <= 1'b0;
    end else begin
      pix_q <= nxt_pix;
      sub_q <= nxt_sub;
      act_q <= nxt_act;
      mir_q <= nxt_mir;
      cr_q  <= nxt_cr;
    end
  end

endmodule

// File: rtl/ccd_lt_hdec.sv
module ccd_lt_hdec #(
  parameter int PIX_W    = 11,
  parameter int SUB_W    = 3,
  parameter int HOLD     = 72,
  parameter int DUMMY    = 7,
  parameter int BLACK    = 20,
  parameter int TIMING   = 4,
  parameter int ACTIVE   = 1024,
  parameter int CB_START = 1131,
  parameter int CB_END   = 99
) (
  input  logic [PIX_W-1:0] pix,
  input  logic [SUB_W-1:0] sub,
  input  logic             mir,
  output logic [2:0]       hreg,
  output logic             rg,
  output logic             stop,
  output logic             pvalid,
  output logic             clamp,
  output logic             blank,
  output logic             lstart
);
  import ccd_lt_pkg::*;

  localparam int LEAD      = DUMMY + BLACK + TIMING;
  localparam int ACT_LO    = HOLD + LEAD;
  localparam int BLK1_LO   = HOLD + DUMMY;
  localparam int BLK2_LO   = ACT_LO + ACTIVE + TIMING;
  localparam logic [2:0] FROZEN = 3'b001;

  int p;
  int s;
  logic [2:0] base;

  assign p = int'(pix);
  assign s = int'(sub);

  assign stop = (p < HOLD);
  assign base = stop ? FROZEN : hphase(s);
  assign hreg = mir ? {base[2], base[0], base[1]} : base;
  assign rg   = !stop && (s == 0);

  assign pvalid = in_span(p, ACT_LO, ACTIVE);
  assign clamp  = in_span(p, BLK1_LO, BLACK) || in_span(p, BLK2_LO, BLACK);
  assign blank  = (p >= CB_START) || (p <= CB_END);
  assign lstart = (p == 0) && (s == 0);

endmodule

// File: rtl/ccd_lt_vdec.sv
module ccd_lt_vdec #(
  parameter int PIX_W       = 11,
  parameter int STORE_BEGIN = 19,
  parameter int STORE_STEP  = 6,
  parameter int PUMP_BEGIN  = 19,
  parameter int PUMP_STEP   = 6,
  parameter int CR_BEGIN    = 19,
  parameter int CR_LEN      = 46
) (
  input  logic [PIX_W-1:0] pix,
  input  logic             cr_en,
  output logic [3:0]       stor,
  output logic [3:0]       img,
  output logic             crst
);
  import ccd_lt_pkg::*;

  localparam int STORE_LEN = VSTATES * STORE_STEP;
  localparam int PUMP_LEN  = VSTATES * PUMP_STEP;

  int p;
  int sw;
  int pw;
  logic s_in;
  logic p_in;

  assign p    = int'(pix);
  assign s_in = in_span(p, STORE_BEGIN, STORE_LEN);
  assign p_in = in_span(p, PUMP_BEGIN, PUMP_LEN);
  assign sw   = s_in ? (p - STORE_BEGIN) / STORE_STEP : 0;
  assign pw   = p_in ? (p - PUMP_BEGIN) / PUMP_STEP : 0;

  assign stor = s_in ? four_phase((sw + 1) % VSTATES) : VREST;
  assign img  = p_in ? four_phase(pump_state(pw)) : VREST;
  assign crst = cr_en && in_span(p, CR_BEGIN, CR_LEN);

endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer #(
  parameter int LINE        = 1152,
  parameter int HOLD        = 72,
  parameter int DUMMY       = 7,
  parameter int BLACK       = 20,
  parameter int TIMING      = 4,
  parameter int ACTIVE      = 1024,
  parameter int CB_START    = 1131,
  parameter int CB_END      = 99,
  parameter int STORE_BEGIN = 19,
  parameter int STORE_STEP  = 6,
  parameter int PUMP_BEGIN  = 19,
  parameter int PUMP_STEP   = 6,
  parameter int CR_BEGIN    = 19,
  parameter int CR_LEN      = 46
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       mirror,
  input  logic       shutter,
  output logic [2:0] hreg_o,
  output logic       rg_o,
  output logic [3:0] stor_o,
  output logic [3:0] img_o,
  output logic       crst_o,
  output logic       stop_o,
  output logic       blank_o,
  output logic       clamp_o,
  output logic       pvalid_o,
  output logic       lstart_o
);
  import ccd_lt_pkg::*;

  localparam int PIX_W = $clog2(LINE);
  localparam int SUB_W = $clog2(SUBS);
  localparam int READ_CELLS = 2 * (DUMMY + BLACK + TIMING) + ACTIVE;

  initial begin
    if (HOLD + READ_CELLS - DUMMY > LINE)
      $error("readout does not fit in the line");
    if (STORE_BEGIN + VSTATES * STORE_STEP > HOLD)
      $error("storage cycle leaves the stopped window");
    if (PUMP_BEGIN + VSTATES * PUMP_STEP > HOLD)
      $error("charge pump leaves the stopped window");
  end

  logic [PIX_W-1:0] nxt_pix, pix_q;
  logic [SUB_W-1:0] nxt_sub, sub_q;
  logic             nxt_act, act_q;
  logic             nxt_mir, mir_q;
  logic             nxt_cr, cr_q;

  ccd_lt_seq #(.LINE(LINE), .PIX_W(PIX_W), .SUB_W(SUB_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .mirror  (mirror),
    .shutter (shutter),
    .nxt_pix (nxt_pix),
    .nxt_sub (nxt_sub),
    .nxt_act (nxt_act),
    .nxt_mir (nxt_mir),
    .nxt_cr  (nxt_cr),
    .pix_q   (pix_q),
    .sub_q   (sub_q),
    .act_q   (act_q),
    .mir_q   (mir_q),
    .cr_q    (cr_q)
  );

  logic [2:0] d_hreg;
  logic       d_rg, d_stop, d_pvalid, d_clamp, d_blank, d_lstart;
  logic [3:0] d_stor, d_img;
  logic       d_crst;

  ccd_lt_hdec #(
    .PIX_W(PIX_W), .SUB_W(SUB_W), .HOLD(HOLD), .DUMMY(DUMMY), .BLACK(BLACK),
    .TIMING(TIMING), .ACTIVE(ACTIVE), .CB_START(CB_START), .CB_END(CB_END)
  ) u_hdec (
    .pix    (nxt_pix),
    .sub    (nxt_sub),
    .mir    (nxt_mir),
    .hreg   (d_hreg),
    .rg     (d_rg),
    .stop   (d_stop),
    .pvalid (d_pvalid),
    .clamp  (d_clamp),
    .blank  (d_blank),
    .lstart (d_lstart)
  );

  ccd_lt_vdec #(
    .PIX_W(PIX_W), .STORE_BEGIN(STORE_BEGIN), .STORE_STEP(STORE_STEP),
    .PUMP_BEGIN(PUMP_BEGIN), .PUMP_STEP(PUMP_STEP),
    .CR_BEGIN(CR_BEGIN), .CR_LEN(CR_LEN)
  ) u_vdec (
    .pix   (nxt_pix),
    .cr_en (nxt_cr),
    .stor  (d_stor),
    .img   (d_img),
    .crst  (d_crst)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hreg_o   <= '0;
      rg_o     <= 1'b0;
      stor_o   <= '0;
      img_o    <= '0;
      crst_o   <= 1'b0;
      stop_o   <= 1'b0;
      blank_o  <= 1'b0;
      clamp_o  <= 1'b0;
      pvalid_o <= 1'b0;
      lstart_o <= 1'b0;
    end else if (!nxt_act) begin
      hreg_o   <= '0;
      rg_o     <= 1'b0;
      stor_o   <= '0;
      img_o    <= '0;
      crst_o   <= 1'b0;
      stop_o   <= 1'b0;
      blank_o  <= 1'b0;
      clamp_o  <= 1'b0;
      pvalid_o <= 1'b0;
      lstart_o <= 1'b0;
    end else begin
      hreg_o   <= d_hreg;
      rg_o     <= d_rg;
      stor_o   <= d_stor;
      img_o    <= d_img;
      crst_o   <= d_crst;
      stop_o   <= d_stop;
      blank_o  <= d_blank;
      clamp_o  <= d_clamp;
      pvalid_o <= d_pvalid;
      lstart_o <= d_lstart;
    end
  end

endmodule

// File: rtl/ccd_lt_chk.sv
module ccd_lt_chk #(
  parameter int LINE  = 1152,
  parameter int PIX_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       hreg_o,
  input logic             rg_o,
  input logic [3:0]       stor_o,
  input logic [3:0]       img_o,
  input logic             crst_o,
  input logic             stop_o,
  input logic             blank_o,
  input logic             clamp_o,
  input logic             pvalid_o,
  input logic             lstart_o,
  input logic [PIX_W-1:0] pix_q,
  input logic             act_q,
  input logic             mir_q
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> (hreg_o == 3'b000 && !rg_o && !lstart_o && stor_o == 4'b0000 && !pvalid_o)); // R1

  AST_PIX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pix_q) < LINE); // R2

  AST_LSTART_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
    lstart_o |-> (stop_o && blank_o && pix_q == '0)); // R2

  AST_HREG_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !stop_o) |-> ($countones(hreg_o) == 1 || $countones(hreg_o) == 2)); // R3

  AST_STOP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_o && $past(stop_o)) |-> $stable(hreg_o)); // R4

  AST_MIRROR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !lstart_o) |-> $stable(mir_q)); // R5

  AST_RG_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    rg_o |-> !stop_o); // R6

  AST_PVALID_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    pvalid_o |-> !(stop_o || blank_o || clamp_o)); // R7

  AST_VERT_REST: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !stop_o) |-> (stor_o == 4'b0110 && img_o == 4'b0110 && !crst_o)); // R10

endmodule

bind ccd_line_timer ccd_lt_chk #(.LINE(LINE), .PIX_W(PIX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hreg_o   (hreg_o),
  .rg_o     (rg_o),
  .stor_o   (stor_o),
  .img_o    (img_o),
  .crst_o   (crst_o),
  .stop_o   (stop_o),
  .blank_o  (blank_o),
  .clamp_o  (clamp_o),
  .pvalid_o (pvalid_o),
  .lstart_o (lstart_o),
  .pix_q    (pix_q),
  .act_q    (act_q),
  .mir_q    (mir_q)
);

// File: tb/test_ccd_line_timer.sv
module test_ccd_line_timer;

  localparam int NLINE = 1152;
  localparam int LCLK  = NLINE * 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic mirror = 1'b0;
  logic shutter = 1'b0;
  logic [2:0] hreg_o;
  logic rg_o, crst_o, stop_o, blank_o, clamp_o, pvalid_o, lstart_o;
  logic [3:0] stor_o, img_o;

  always #5 clk = ~clk;

  ccd_line_timer i_ccd_line_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .mirror(mirror), .shutter(shutter),
    .hreg_o(hreg_o), .rg_o(rg_o), .stor_o(stor_o), .img_o(img_o),
    .crst_o(crst_o), .stop_o(stop_o), .blank_o(blank_o), .clamp_o(clamp_o),
    .pvalid_o(pvalid_o), .lstart_o(lstart_o)
  );

  int checks = 0;
  int errors = 0;
  int m_pix = NLINE - 1;
  int m_sub = 5;
  bit m_act = 0;
  bit m_mir = 0;
  bit m_cr = 0;
  int starts = 0;
  bit done = 0;

  // Reference model: advances on each rising edge from the sampled inputs.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !run) begin
      m_act = 0;
      m_pix = NLINE - 1;
      m_sub = 5;
    end else begin
      m_act = 1;
      m_sub = m_sub + 1;
      if (m_sub == 6) begin
        m_sub = 0;
        m_pix = (m_pix + 1) % NLINE;
      end
      if (m_pix == 0 && m_sub == 0) begin
        m_mir = mirror;
        m_cr = shutter;
        starts++;
      end
    end
  end

  function automatic logic [3:0] vtab(input int t);
    case (t)
      0: return 4'b0110;
      1: return 4'b1110;
      2: return 4'b1100;
      3: return 4'b1101;
      4: return 4'b1001;
      5: return 4'b1011;
      6: return 4'b0011;
      default: return 4'b0111;
    endcase
  endfunction

  function automatic logic [2:0] exp_hreg(input int p, input int s, input bit mr);
    logic [2:0] h;
    if (p < 72) h = 3'b001;
    else begin
      h[0] = (s <= 2);
      h[1] = (s >= 2 && s <= 4);
      h[2] = (s >= 4 || s == 0);
    end
    if (mr) h = {h[2], h[0], h[1]};
    return h;
  endfunction

  function automatic logic [3:0] exp_stor(input int p);
    if (p < 19 || p > 66) return vtab(0);
    return vtab(((p - 19) / 6 + 1) % 8);
  endfunction

  function automatic logic [3:0] exp_img(input int p);
    int seq[8] = '{1, 2, 3, 4, 3, 2, 1, 0};
    if (p < 19 || p > 66) return vtab(0);
    return vtab(seq[(p - 19) / 6]);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!m_act) begin
        chk({hreg_o, rg_o, stor_o, img_o, crst_o, stop_o, blank_o, clamp_o, pvalid_o, lstart_o} == '0,
            "R1 idle outputs", {hreg_o, stor_o, img_o}, 0);
      end else begin
        logic [2:0] eh;
        eh = exp_hreg(m_pix, m_sub, m_mir);
        chk(hreg_o == eh, (m_pix < 72) ? "R4/R5 frozen hreg" : (m_mir ? "R5 mirrored hreg" : "R3 hreg"),
            hreg_o, eh);
        chk(stop_o == (m_pix < 72), "R4 stop", stop_o, m_pix < 72);
        chk(rg_o == (m_pix >= 72 && m_sub == 0), "R6 rg", rg_o, m_pix >= 72 && m_sub == 0);
        chk(pvalid_o == (m_pix >= 103 && m_pix <= 1126), "R7 pvalid", pvalid_o,
            m_pix >= 103 && m_pix <= 1126);
        chk(clamp_o == ((m_pix >= 79 && m_pix <= 98) || (m_pix >= 1131 && m_pix <= 1150)),
            "R8 clamp", clamp_o, (m_pix >= 79 && m_pix <= 98) || (m_pix >= 1131 && m_pix <= 1150));
        chk(blank_o == (m_pix >= 1131 || m_pix <= 99), "R9 blank", blank_o, m_pix >= 1131 || m_pix <= 99);
        chk(stor_o == exp_stor(m_pix), "R10 storage", stor_o, exp_stor(m_pix));
        chk(img_o == exp_img(m_pix), "R11 pump", img_o, exp_img(m_pix));
        chk(crst_o == (m_cr && m_pix >= 19 && m_pix <= 64), "R12 charge reset", crst_o,
            m_cr && m_pix >= 19 && m_pix <= 64);
        chk(lstart_o == (m_pix == 0 && m_sub == 0), "R2 line start", lstart_o, m_pix == 0 && m_sub == 0);
      end
    end
  end

  int hw_starts = 0;
  always @(negedge clk) if (lstart_o) hw_starts++;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(3);
    run = 1'b1;               // R1: first running clock is pixel 0
    cyc(3000);
    mirror = 1'b1;            // R5, R12: mid-line requests must wait
    shutter = 1'b1;
    cyc(LCLK);
    mirror = 1'b0;            // line now mirrored; change ignored until next line
    cyc(LCLK - 2000);
    shutter = 1'b0;
    cyc(2500);
    run = 1'b0;               // R1: drop mid-line
    cyc(20);
    run = 1'b1;
    cyc(2 * LCLK + 100);
    chk(hw_starts == starts && starts >= 4, "R2 line count", hw_starts, starts);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule